// File: doc/BRIEF.md
# Exception Priority and Vectoring Unit

This unit sits next to a small processor core and decides which exception the core services next. Five sources can raise a request: a system reset, a machine check, an instruction-dependent fault, an external interrupt and a decrementer interrupt. The four non-reset sources are captured into sticky pending flags. Each flag is gated by the enable bits of a two-bit machine state register, and the unit selects the single enabled request of highest priority. It then offers the core the start address of that exception's handler slot in a 16 KB table made of 256-byte slots.

The handler address leaves the unit as a valid/ready stream. `vec_valid` high means a handler address is on offer. The exception counts as taken only on a cycle where `vec_valid` and `vec_ready` are both high. While `vec_ready` stays low, nothing is lost: every pending flag stays set. The offer is not frozen during back-pressure, though. A newly arrived request of higher priority replaces the address on offer, and a change to the enable bits can withdraw the offer. The core should therefore act on the address it sees in the accepting cycle.

Taking an exception moves the current enable bits into a shadow copy and clears both live enable bits. A return strobe copies the shadow back. A machine check that arrives while machine checks are disabled puts the unit into a halted state. In that state it offers no vector until a system reset. The system reset itself cannot be masked and is offered in the very cycle it is asserted.

Top module: `exc_vector_unit`

## Requirements
- R1: Priority from highest to lowest is system reset, machine check, instruction fault, external, decrementer. The offered address is `VEC_BASE + slot*256`, with slot 1 for reset, 2 for machine check, 7 for instruction fault, 5 for external and 9 for decrementer.
- R2: While `sys_rst_req` is high, `vec_valid` is high in that same cycle with the reset slot address. The following clock edge clears all pending flags, both enable bits, the shadow copy and the halted state.
- R3: A pulse on `mchk_req`, `fault_req`, `ext_req` or `dec_req` is captured at a clock edge and can be offered from the cycle right after that edge.
- R4: A machine check request is captured only when `msr_me` is 1. If it is sampled while `msr_me` is 0, `checkstop` rises at that edge. From then on `vec_valid` stays low, whatever is pending, until a system reset.
- R5: The single bit `msr_ee` gates both external and decrementer requests. While it is 0, both stay pending without being offered, and lower-priority or unmasked sources are offered instead.
- R6: A pending flag is cleared only by acceptance of its own vector (`vec_valid` and `vec_ready` high). If a new request of the same source is sampled at the accepting edge, the flag stays set.
- R7: On acceptance, the shadow copy takes {`msr_ee`,`msr_me`} and both live bits become 0 at that edge.
- R8: A pulse on `rfe_strobe` copies the shadow back into {`msr_ee`,`msr_me`}. If acceptance happens in the same cycle, acceptance wins.
- R9: `msr_wr` loads `msr_wdata` (bit 1 into `msr_ee`, bit 0 into `msr_me`). It does so only when there is no reset, acceptance or return strobe in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sys_rst_req | input | 1 | System reset exception request (level) |
| mchk_req | input | 1 | Machine check request pulse |
| fault_req | input | 1 | Instruction-dependent fault request pulse |
| ext_req | input | 1 | External interrupt request pulse |
| dec_req | input | 1 | Decrementer interrupt request pulse |
| msr_wr | input | 1 | Load strobe for the enable bits |
| msr_wdata | input | 2 | New enable bits: [1] external/decrementer, [0] machine check |
| rfe_strobe | input | 1 | Return from exception, restores enables from the shadow copy |
| vec_valid | output | 1 | Handler address on offer |
| vec_ready | input | 1 | Core accepts the offered handler |
| vec_addr | output | ADDR_W | Handler slot address |
| msr_ee | output | 1 | External/decrementer enable bit |
| msr_me | output | 1 | Machine check enable bit |
| checkstop | output | 1 | Core halted by a masked machine check |

## Verification
The bench builds the unit with a 32-bit address and a table base of 32'hFFF0_4000 instead of the default base. The slot offsets are therefore added on top of a non-zero base with high bits set, and an error in the base sum or the slot shift shows up in the upper address bits. Random request, ready, return and write traffic runs against a bench model, with both enable bits toggling freely. This reaches the masked-pending, halt-and-recover and same-cycle collision cases in many orders, alongside the directed sequences for each of them.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSRC       = 4;
  localparam int SLOT_SHIFT = 8;
  localparam int SLOT_W     = 6;

  // source positions in the pending bank, lowest position wins
  localparam int SRC_MCHK  = 0;
  localparam int SRC_FAULT = 1;
  localparam int SRC_EXT   = 2;
  localparam int SRC_DEC   = 3;

  localparam logic [SLOT_W-1:0] SLOT_RST   = 6'd1;
  localparam logic [SLOT_W-1:0] SLOT_MCHK  = 6'd2;
  localparam logic [SLOT_W-1:0] SLOT_FAULT = 6'd7;
  localparam logic [SLOT_W-1:0] SLOT_EXT   = 6'd5;
  localparam logic [SLOT_W-1:0] SLOT_DEC   = 6'd9;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [1:0] src);
    case (src)
      2'd0:    slot_of = SLOT_MCHK;
      2'd1:    slot_of = SLOT_FAULT;
      2'd2:    slot_of = SLOT_EXT;
      default: slot_of = SLOT_DEC;
    endcase
  endfunction
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_o[g] <= 1'b0;
      else if (flush)
        pend_o[g] <= 1'b0;
      else
        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
    end
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign blocked[g] = blocked[g-1] | req_i[g-1];
  end

  assign gnt_o = req_i & ~blocked;
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/exc_msr_ctl.sv
module exc_msr_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       take,
  input  logic       rfe,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       mchk_req,
  output logic       ee,
  output logic       me,
  output logic [1:0] shadow,
  output logic       halted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee     <= 1'b0;
      me     <= 1'b0;
      shadow <= 2'b00;
      halted <= 1'b0;
    end else if (sys_rst) begin
      ee     <= 1'b0;
      me     <= 1'b0;
      shadow <= 2'b00;
      halted <= 1'b0;
    end else begin
      if (take) begin
        shadow <= {ee, me};
        ee     <= 1'b0;
        me     <= 1'b0;
      end else if (rfe) begin
        ee <= shadow[1];
        me <= shadow[0];
      end else if (wr) begin
        ee <= wdata[1];
        me <= wdata[0];
      end
      if (mchk_req && !me) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0001_C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_req,
  input  logic              mchk_req,
  input  logic              fault_req,
  input  logic              ext_req,
  input  logic              dec_req,
  input  logic              msr_wr,
  input  logic [1:0]        msr_wdata,
  input  logic              rfe_strobe,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              msr_ee,
  output logic              msr_me,
  output logic              checkstop
);
  import exc_pkg::*;
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] pend, set_v, enab, live, gnt;
  logic            any_live, take;
  logic [IW-1:0]   sel;
  logic [1:0]      msr_shadow;
  logic [SLOT_W-1:0] slot;

  assign set_v[SRC_MCHK]  = mchk_req & msr_me;
  assign set_v[SRC_FAULT] = fault_req;
  assign set_v[SRC_EXT]   = ext_req;
  assign set_v[SRC_DEC]   = dec_req;

  assign enab[SRC_MCHK]  = msr_me;
  assign enab[SRC_FAULT] = 1'b1;
  assign enab[SRC_EXT]   = msr_ee;
  assign enab[SRC_DEC]   = msr_ee;

  assign live = pend & enab;

  exc_pend_bank #(.N(NSRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .flush(sys_rst_req),
    .set_i(set_v), .clr_i(gnt & {NSRC{take}}), .pend_o(pend)
  );

  exc_prio_pick #(.N(NSRC)) pick_i (
    .req_i(live), .gnt_o(gnt), .any_o(any_live), .idx_o(sel)
  );

  exc_msr_ctl msr_i (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst_req), .take(take),
    .rfe(rfe_strobe), .wr(msr_wr), .wdata(msr_wdata), .mchk_req(mchk_req),
    .ee(msr_ee), .me(msr_me), .shadow(msr_shadow), .halted(checkstop)
  );

  assign vec_valid = sys_rst_req | (~checkstop & any_live);
  assign take      = vec_valid & vec_ready & ~sys_rst_req;
  assign slot      = sys_rst_req ? SLOT_RST : slot_of(2'(sel));
  assign vec_addr  = ADDR_W'(VEC_BASE) + (ADDR_W'(slot) << SLOT_SHIFT);
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0001_C000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_req,
  input logic              mchk_req,
  input logic              rfe_strobe,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              msr_ee,
  input logic              msr_me,
  input logic              checkstop,
  input logic [1:0]        msr_shadow
);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(VEC_BASE) + ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(VEC_BASE) + ADDR_W'(32'h500);
  localparam logic [ADDR_W-1:0] A_DEC = ADDR_W'(VEC_BASE) + ADDR_W'(32'h900);

  a_r2_reset_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (vec_valid && vec_addr == A_RST));

  a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> (!msr_ee && !msr_me && !checkstop));

  a_r4_halt_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (mchk_req && !msr_me && !sys_rst_req) |=> checkstop);

  a_r4_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (checkstop && !sys_rst_req) |-> !vec_valid);

  a_r5_ee_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !msr_ee && !sys_rst_req) |-> (vec_addr != A_EXT && vec_addr != A_DEC));

  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !sys_rst_req) |=> (!msr_ee && !msr_me &&
      msr_shadow == {$past(msr_ee), $past(msr_me)}));

  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_strobe && !sys_rst_req && !(vec_valid && vec_ready)) |=>
      ({msr_ee, msr_me} == $past(msr_shadow)));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .mchk_req(mchk_req),
  .rfe_strobe(rfe_strobe), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_addr(vec_addr), .msr_ee(msr_ee), .msr_me(msr_me), .checkstop(checkstop),
  .msr_shadow(msr_shadow)
);

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;
  localparam int          CLK_P = 10;
  localparam int          AW    = 32;
  localparam logic [31:0] BASE  = 32'hFFF0_4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_rst_req = 0, mchk_req = 0, fault_req = 0, ext_req = 0, dec_req = 0;
  logic msr_wr = 0, rfe_strobe = 0, vec_ready = 0;
  logic [1:0] msr_wdata = 2'b00;
  logic vec_valid, msr_ee, msr_me, checkstop;
  logic [AW-1:0] vec_addr;

  int checks = 0, failures = 0;
  // bench model state: pend bits {dec,ext,fault,mchk}
  logic [3:0] m_pend = 0;
  logic m_ee = 0, m_me = 0, m_cs = 0;
  logic [1:0] m_sh = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_vector_unit #(.ADDR_W(AW), .VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .mchk_req(mchk_req),
    .fault_req(fault_req), .ext_req(ext_req), .dec_req(dec_req), .msr_wr(msr_wr),
    .msr_wdata(msr_wdata), .rfe_strobe(rfe_strobe), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .msr_ee(msr_ee), .msr_me(msr_me),
    .checkstop(checkstop)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] en_mask();
    return {m_ee, m_ee, 1'b1, m_me};
  endfunction

  function automatic logic exp_valid(input logic r);
    return r | (!m_cs && |(m_pend & en_mask()));
  endfunction

  function automatic logic [5:0] exp_slot(input logic r);
    logic [3:0] l;
    l = m_pend & en_mask();
    if (r) return 6'd1;
    if (l[0]) return 6'd2;
    if (l[1]) return 6'd7;
    if (l[2]) return 6'd5;
    return 6'd9;
  endfunction

  function automatic logic [3:0] pick(input logic [3:0] l);
    if (l[0]) return 4'b0001;
    if (l[1]) return 4'b0010;
    if (l[2]) return 4'b0100;
    if (l[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  // one clock: drive, check outputs against model, then advance model
  task automatic cyc(input string tag, input logic r, input logic mc, input logic fl,
                     input logic ex, input logic dc, input logic wr, input logic [1:0] wd,
                     input logic rf, input logic rdy);
    logic ev, tk;
    logic [3:0] n_pend;
    @(negedge clk);
    sys_rst_req = r; mchk_req = mc; fault_req = fl; ext_req = ex; dec_req = dc;
    msr_wr = wr; msr_wdata = wd; rfe_strobe = rf; vec_ready = rdy;
    #1;
    ev = exp_valid(r);
    chk({tag, " valid"}, 64'(vec_valid), 64'(ev));
    if (ev) chk({tag, " addr"}, 64'(vec_addr), 64'(BASE + (32'(exp_slot(r)) << 8)));
    chk({tag, " ee"}, 64'(msr_ee), 64'(m_ee));
    chk({tag, " me"}, 64'(msr_me), 64'(m_me));
    chk({tag, " checkstop"}, 64'(checkstop), 64'(m_cs));
    @(posedge clk);
    if (r) begin
      m_pend = 0; m_ee = 0; m_me = 0; m_sh = 0; m_cs = 0;
    end else begin
      tk = ev & rdy;
      n_pend = m_pend & ~(tk ? pick(m_pend & en_mask()) : 4'b0000);
      n_pend = n_pend | {dc, ex, fl, mc & m_me};
      if (mc && !m_me) m_cs = 1;
      if (tk) begin m_sh = {m_ee, m_me}; m_ee = 0; m_me = 0; end
      else if (rf) begin m_ee = m_sh[1]; m_me = m_sh[0]; end
      else if (wr) begin m_ee = wd[1]; m_me = wd[0]; end
      m_pend = n_pend;
    end
  endtask

  task automatic idle(input string tag, input logic rdy);
    cyc(tag, 0, 0, 0, 0, 0, 0, 2'b00, 0, rdy);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R2 reset state", 1);

    // R2: system reset vector offered in the same cycle
    cyc("R2 sysreset", 1, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    // R9: enable both
    cyc("R9 write", 0, 0, 0, 0, 0, 1, 2'b11, 0, 0);
    // R3 R5: ext and dec together, ext first; R6 hold under back-pressure
    cyc("R3 req", 0, 0, 0, 1, 1, 0, 2'b00, 0, 0);
    idle("R1 ext over dec", 0);
    idle("R6 hold", 0);
    idle("R7 accept", 1);
    idle("R5 dec masked after take", 1);
    // R8: return restores, dec then offered
    cyc("R8 rfe", 0, 0, 0, 0, 0, 0, 2'b00, 1, 0);
    idle("R5 dec offered", 0);
    // R8: accept and return same cycle, accept wins
    cyc("R8 collide", 0, 0, 0, 0, 0, 0, 2'b00, 1, 1);
    cyc("R9 write", 0, 0, 0, 0, 0, 1, 2'b11, 0, 0);
    // R1: all at once, machine check first
    cyc("R1 all", 0, 1, 1, 1, 1, 0, 2'b00, 0, 0);
    idle("R1 mchk first", 1);
    cyc("R6 rearm same edge", 0, 0, 1, 0, 0, 0, 2'b00, 0, 1);
    idle("R6 fault again", 1);
    idle("R5 ext masked", 1);
    // R4: machine check while disabled halts
    cyc("R4 masked mchk", 0, 1, 1, 0, 0, 0, 2'b00, 0, 0);
    idle("R4 halted", 1);
    idle("R4 halted2", 1);
    cyc("R2 recover", 1, 0, 0, 0, 0, 0, 2'b00, 0, 1);
    idle("R2 after reset", 1);

    for (int i = 0; i < 4000; i++) begin
      logic r, mc, fl, ex, dc, wr, rf, rdy;
      r   = ($urandom % 60) == 0;
      mc  = ($urandom % 25) == 0;
      fl  = ($urandom % 8) == 0;
      ex  = ($urandom % 6) == 0;
      dc  = ($urandom % 6) == 0;
      wr  = ($urandom % 5) == 0;
      rf  = ($urandom % 7) == 0;
      rdy = ($urandom % 2) == 0;
      cyc("R1 R3 R4 R5 R6 R7 R8 R9 random", r, mc, fl, ex, dc, wr, 2'($urandom), rf, rdy);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule